// File: doc/BRIEF.md
# DRAM Refresh Address Generator

This block holds the refresh counter of an 8-bit processor core and produces the refresh phase that follows every opcode-fetch machine cycle. During the last two T-states of each opcode-fetch cycle, it places a refresh address on the address bus. The upper byte of that address comes from the interrupt-vector register and the lower byte from the refresh counter. It also asserts the refresh strobe and the memory-request strobe, both active low. Outside that window it releases the address bus and keeps both strobes inactive.

The counter advances once per opcode-fetch cycle, at the clock edge that ends the final T-state. Only its low seven bits count. The top bit changes only when the core loads the whole register from the accumulator. The interrupt-vector register also has a load path from the accumulator. The present counter value is always available for a read-back path, and it already reflects the increment made in the current fetch cycle.

Top module: `rfsh_addr_gen`

## Requirements
- R1: The refresh counter advances exactly once per opcode-fetch cycle, on the clock edge that ends the T4 state. Extra wait cycles spent in T2 do not add increments.
- R2: Only bits 6..0 count. They wrap from 7Fh to 00h.
- R3: Counting never alters bit 7 of the refresh counter.
- R4: A counter load (`r_load`) writes all 8 bits from `acc_data` on the next clock edge. When a load and an increment fall on the same edge, the load wins.
- R5: After an opcode-fetch cycle ends, `r_value` shows the counter value that includes that cycle's increment.
- R6: While the refresh window is open, `rfsh_addr` equals {interrupt-vector register, refresh counter}, with the vector register in bits 15..8.
- R7: The refresh window is open exactly when `m1_cyc` is 1 and `tstate` is 2 (T3) or 3 (T4). In that window, `rfsh_n` and `mreq_n` are both 0. `tstate` codes are 0=T1, 1=T2, 2=T3, 3=T4.
- R8: Outside the refresh window, `rfsh_n` and `mreq_n` are 1, `addr_drive` is 0, and `rfsh_addr` is 0.
- R9: Reset clears both the refresh counter and the interrupt-vector register to 00h.
- R10: A vector load (`i_load`) writes `acc_data` into the interrupt-vector register on the next clock edge. The new value appears in the upper address byte of later refresh windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T-state |
| rst_n | input | 1 | Asynchronous reset, active low |
| m1_cyc | input | 1 | High during an opcode-fetch machine cycle |
| tstate | input | 2 | Current T-state code (0=T1 .. 3=T4) |
| acc_data | input | 8 | Accumulator value for register loads |
| r_load | input | 1 | Load the refresh counter from acc_data |
| i_load | input | 1 | Load the interrupt-vector register from acc_data |
| rfsh_addr | output | 16 | Refresh address, valid when addr_drive is high |
| addr_drive | output | 1 | High while the block drives the address bus |
| rfsh_n | output | 1 | Refresh strobe, active low |
| mreq_n | output | 1 | Memory request for the refresh window, active low |
| r_value | output | 8 | Current refresh counter value for read-back |

## Verification
The checker watches every cycle and confirms several invariants. Bit 7 stays fixed unless a load occurs. Without a load, the counter either holds or steps its low seven bits by one, and it steps only on an edge that ends T4 of a fetch cycle. The two strobes move together with the address-drive flag. Other properties can only be shown by the bench's scenarios, because they depend on history across whole fetch cycles. These are the exact address composition, the 7Fh-to-00h wrap with either top-bit value, load priority at the T4 edge, stretched fetch cycles producing a single increment, and the reset values.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
   typedef enum logic [1:0] {
      TS_T1 = 2'd0,
      TS_T2 = 2'd1,
      TS_T3 = 2'd2,
      TS_T4 = 2'd3
   } tstate_e;
endpackage

// File: rtl/rfsh_window.sv
// Decodes the refresh window and issues a single bump per fetch cycle.
module rfsh_window
   import rfsh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       m1_cyc,
   input  logic [1:0] tstate,
   output logic       win_open,
   output logic       bump
);
   logic in_t4;
   logic bumped_q;

   assign win_open = m1_cyc && ((tstate == TS_T3) || (tstate == TS_T4));
   assign in_t4    = m1_cyc && (tstate == TS_T4);
   assign bump     = in_t4 && !bumped_q;

   // guards against a T4 held over several clocks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bumped_q <= 1'b0;
      else
         bumped_q <= in_t4;
   end
endmodule

// File: rtl/rfsh_counter.sv
// Refresh counter: the low CNT_W bits count, the upper bits hold.
module rfsh_counter #(
   parameter int REG_W = 8,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   input  logic             load,
   input  logic [REG_W-1:0] din,
   output logic [REG_W-1:0] q
);
   localparam int HOLD_W = REG_W - CNT_W;

   logic [REG_W-1:0] nxt;

   generate
      if (CNT_W == REG_W) begin : g_full
         assign nxt = q + REG_W'(1);
      end else begin : g_split
         logic [CNT_W-1:0] low_inc;
         assign low_inc = q[CNT_W-1:0] + CNT_W'(1);
         assign nxt     = {q[REG_W-1 -: HOLD_W], low_inc};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= din;
      else if (bump)
         q <= nxt;
   end
endmodule

// File: rtl/rfsh_vecreg.sv
// Interrupt-vector register with a load port.
module rfsh_vecreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= din;
   end
endmodule

// File: rtl/rfsh_addr_gen.sv
module rfsh_addr_gen #(
   parameter int REG_W  = 8,
   parameter int CNT_W  = 7,
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m1_cyc,
   input  logic [1:0]        tstate,
   input  logic [REG_W-1:0]  acc_data,
   input  logic              r_load,
   input  logic              i_load,
   output logic [ADDR_W-1:0] rfsh_addr,
   output logic              addr_drive,
   output logic              rfsh_n,
   output logic              mreq_n,
   output logic [REG_W-1:0]  r_value
);
   localparam int COMP_W = VEC_W + REG_W;

   generate
      if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
         $error("rfsh_addr_gen: CNT_W must lie in 1..REG_W");
      end
      if (COMP_W != ADDR_W) begin : g_bad_addr
         $error("rfsh_addr_gen: ADDR_W must equal VEC_W + REG_W");
      end
      if (VEC_W > REG_W) begin : g_bad_vec
         $error("rfsh_addr_gen: VEC_W may not exceed accumulator width");
      end
   endgenerate

   logic             win_open;
   logic             bump;
   logic [VEC_W-1:0] vec_q;

   rfsh_window u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .m1_cyc   (m1_cyc),
      .tstate   (tstate),
      .win_open (win_open),
      .bump     (bump)
   );

   rfsh_counter #(.REG_W(REG_W), .CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (bump),
      .load  (r_load),
      .din   (acc_data),
      .q     (r_value)
   );

   rfsh_vecreg #(.W(VEC_W)) u_vec (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (i_load),
      .din   (acc_data[VEC_W-1:0]),
      .q     (vec_q)
   );

   assign addr_drive = win_open;
   assign rfsh_n     = !win_open;
   assign mreq_n     = !win_open;
   assign rfsh_addr  = win_open ? {vec_q, r_value} : '0;
endmodule

// File: rtl/rfsh_addr_gen_chk.sv
module rfsh_addr_gen_chk #(
   parameter int REG_W  = 8,
   parameter int CNT_W  = 7,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m1_cyc,
   input logic [1:0]        tstate,
   input logic              r_load,
   input logic [ADDR_W-1:0] rfsh_addr,
   input logic              addr_drive,
   input logic              rfsh_n,
   input logic              mreq_n,
   input logic [REG_W-1:0]  r_value
);
   generate
      if (CNT_W < REG_W) begin : g_hold
         assert_top_bit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !r_load |=> r_value[REG_W-1] == $past(r_value[REG_W-1]));
      end
   endgenerate

   assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !r_load |=> (r_value == $past(r_value)) ||
                  (r_value[CNT_W-1:0] == CNT_W'($past(r_value[CNT_W-1:0]) + 1)));

   assert_step_only_at_t4_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(m1_cyc && tstate == 2'd3) && !r_load |=> $stable(r_value));

   assert_strobes_paired_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_n == mreq_n) && (addr_drive == !rfsh_n));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_n |-> (rfsh_addr == '0));

   assert_low_byte_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_drive |-> (rfsh_addr[REG_W-1:0] == r_value));
endmodule

bind rfsh_addr_gen rfsh_addr_gen_chk #(
   .REG_W(REG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .m1_cyc     (m1_cyc),
   .tstate     (tstate),
   .r_load     (r_load),
   .rfsh_addr  (rfsh_addr),
   .addr_drive (addr_drive),
   .rfsh_n     (rfsh_n),
   .mreq_n     (mreq_n),
   .r_value    (r_value)
);

// File: tb/rfsh_addr_gen_tb.sv
module rfsh_addr_gen_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m1_cyc = 1'b0;
   logic [1:0]  tstate = 2'd0;
   logic [7:0]  acc_data = 8'h00;
   logic        r_load = 1'b0;
   logic        i_load = 1'b0;
   logic [15:0] rfsh_addr;
   logic        addr_drive;
   logic        rfsh_n;
   logic        mreq_n;
   logic [7:0]  r_value;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] r_exp = 8'h00;
   logic [7:0] i_exp = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   rfsh_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .m1_cyc(m1_cyc), .tstate(tstate),
      .acc_data(acc_data), .r_load(r_load), .i_load(i_load),
      .rfsh_addr(rfsh_addr), .addr_drive(addr_drive), .rfsh_n(rfsh_n),
      .mreq_n(mreq_n), .r_value(r_value)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      check(req, {rfsh_n, mreq_n, addr_drive}, 3'b110);
      check(req, rfsh_addr, 32'h0);
   endtask

   task automatic check_window(input string req);
      check(req, {rfsh_n, mreq_n, addr_drive}, 3'b001);
      check(req, rfsh_addr, {16'h0, i_exp, r_exp});
   endtask

   // one opcode-fetch cycle; optional counter load during T4
   task automatic fetch(input int waits, input bit ld_t4, input logic [7:0] v);
      @(negedge clk); m1_cyc = 1'b1; tstate = 2'd0;
      #1 check_idle("R8 T1");
      @(negedge clk); tstate = 2'd1;
      #1 check_idle("R8 T2");
      for (int w = 0; w < waits; w++) begin
         @(negedge clk);
         #1 check("R1 no step in wait", r_value, r_exp);
      end
      @(negedge clk); tstate = 2'd2;
      #1 check_window("R6 R7 T3");
      @(negedge clk); tstate = 2'd3;
      if (ld_t4) begin r_load = 1'b1; acc_data = v; end
      #1 check_window("R6 R7 T4");
      @(negedge clk); m1_cyc = 1'b0; tstate = 2'd0; r_load = 1'b0;
      if (ld_t4) r_exp = v;
      else r_exp = {r_exp[7], 7'(r_exp[6:0] + 7'd1)};
      #1 check("R5 readback after fetch", r_value, r_exp);
      check_idle("R8 after fetch");
   endtask

   task automatic load_r(input logic [7:0] v);
      @(negedge clk); r_load = 1'b1; acc_data = v;
      @(negedge clk); r_load = 1'b0; r_exp = v;
      #1 check("R4 counter load", r_value, r_exp);
   endtask

   task automatic load_i(input logic [7:0] v);
      @(negedge clk); i_load = 1'b1; acc_data = v;
      @(negedge clk); i_load = 1'b0; i_exp = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 check("R9 counter reset", r_value, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      #1 check_idle("R8 after reset");
      // first window shows a cleared vector register (R9)
      fetch(0, 1'b0, 8'h00);
      // full sweep of the low seven bits with bit 7 clear: wrap 7F->00 (R2, R3)
      for (int k = 0; k < 129; k++) fetch(k % 3, 1'b0, 8'h00);
      check("R2 wrap bit7 clear", r_value, 8'h02);
      // bit 7 set: wrap 0xFF->0x80 keeps bit 7 (R3)
      load_r(8'hFE);
      fetch(0, 1'b0, 8'h00);
      check("R3 bit7 held at FF", r_value, 8'hFF);
      fetch(2, 1'b0, 8'h00);
      check("R3 wrap keeps bit7", r_value, 8'h80);
      // vector register sweep with varied counter values (R10, R6)
      for (int v = 0; v < 256; v += 17) begin
         load_i(8'(v));
         load_r(8'(v * 5 + 3));
         fetch(v % 4, 1'b0, 8'h00);
      end
      // load on the T4 edge beats the increment (R4)
      fetch(1, 1'b1, 8'h3C);
      check("R4 load wins at T4", r_value, 8'h3C);
      fetch(0, 1'b0, 8'h00);
      check("R1 single step after load", r_value, 8'h3D);
      // long wait stretch still yields one step (R1)
      fetch(7, 1'b0, 8'h00);
      check("R1 one step with waits", r_value, 8'h3E);
      // T3/T4 codes without fetch cycle stay quiet (R8)
      @(negedge clk); tstate = 2'd2; #1 check_idle("R8 T3 no fetch");
      @(negedge clk); tstate = 2'd3; #1 check_idle("R8 T4 no fetch");
      @(negedge clk); tstate = 2'd0;
      #1 check("R1 no step outside fetch", r_value, 8'h3E);
      // reset clears both registers (R9)
      rst_n = 1'b0; r_exp = 8'h00; i_exp = 8'h00;
      @(negedge clk); rst_n = 1'b1;
      #1 check("R9 counter cleared", r_value, 8'h00);
      fetch(0, 1'b0, 8'h00);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule